// File: doc/BRIEF.md
# Lexical-Level Operand Address Unit

This unit keeps one base register per lexical level of a block-structured program. Each register holds the word address of the first word of that level's stack frame. An operand is named by an encoded couple that combines a lexical level and a position inside that level's frame. The unit returns the linear address: the base of the chosen level plus the position. Frames can differ in length and can sit anywhere in the address space, so the unit assumes nothing about how one entry relates to another.

An outside controller performs the call and return sequences. It loads or invalidates display entries through a write port, and it updates the current lexical level through a plain load pin. The way a 14-bit couple divides into its two fields depends on the current level. The level field uses the fewest bits that can hold the current level, with a minimum of one bit. The offset takes all of the remaining lower bits.

Operand requests arrive on a valid/ready stream, and results leave on a second valid/ready stream through a single output register. The rules for back-pressure are as follows:
- A request is accepted on a clock edge when `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `resp_valid` is high and `resp_ready` is low, the response stays frozen.

Top module: `lexaddr_unit`

## Requirements
- R1: After reset, every display entry is invalid, `cur_level` is 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: Let W be the bit length of `cur_level`, with a minimum of 1 (for example, 0 and 1 give 1, 5 gives 3, and 31 gives 5). The level is bits [13:14-W] of the couple. The offset is bits [13-W:0], zero-extended.
- R3: For a response without a fault, `resp_addr` equals (base + offset) mod 2^20. `resp_ovf` is 1 exactly when that sum carries out of bit 19.
- R4: A level greater than `cur_level` gives `resp_fault`=1. Any faulting response carries `resp_addr`=0 and `resp_ovf`=0.
- R5: A level whose entry was never written, or was cleared, gives `resp_fault`=1.
- R6: Suppose a display write and an accepted request name the same level in the same cycle. The request then sees the written value: the new base if `wr_clear`=0, or a fault if `wr_clear`=1.
- R7: A request accepted on one edge produces `resp_valid`=1 after that edge. `req_ready` = !resp_valid || resp_ready. A stalled response holds its values.
- R8: `wr_en` with `wr_clear`=0 stores `wr_base` for `wr_level` and marks the entry valid. `wr_en` with `wr_clear`=1 marks it invalid.
- R9: `lvl_we` loads `lvl_value` into `cur_level` on the next edge. A request accepted on that same edge still decodes with the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request |
| req_couple | input | 14 | Encoded level/offset couple |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes response |
| resp_addr | output | 20 | Linear operand address |
| resp_fault | output | 1 | Addressing fault |
| resp_ovf | output | 1 | Carry out of the address sum |
| wr_en | input | 1 | Display write strobe |
| wr_clear | input | 1 | Write invalidates the entry |
| wr_level | input | 5 | Entry being written |
| wr_base | input | 20 | New frame base |
| lvl_we | input | 1 | Load current level |
| lvl_value | input | 5 | New current level |
| cur_level | output | 5 | Current lexical level |

## Verification
A corrupted base or validity bit shows up as a wrong address or a spurious fault in the very next response that selects that level. A bad entry that is never selected stays hidden, so the random stimulus touches every level many times. A wrong field width only becomes visible once `cur_level` moves into a new power-of-two band. For that reason the level is driven across 0, 1, mid and top values, and each response is compared one cycle after its acceptance.

// File: rtl/lexaddr_pkg.sv
package lexaddr_pkg;
  localparam int unsigned NUM_LEVELS = 32;
  localparam int unsigned LVL_W      = $clog2(NUM_LEVELS);
  localparam int unsigned BASE_W     = 20;
  localparam int unsigned COUPLE_W   = 14;

  typedef struct packed {
    logic              fault;
    logic              ovf;
    logic [BASE_W-1:0] addr;
  } resp_t;
endpackage

// File: rtl/lexaddr_display.sv
module lexaddr_display
  import lexaddr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_clear,
  input  logic [LVL_W-1:0]  wr_level,
  input  logic [BASE_W-1:0] wr_base,
  input  logic [LVL_W-1:0]  rd_level,
  output logic [BASE_W-1:0] rd_base,
  output logic              rd_ok
);
  logic [BASE_W-1:0]     base_q [NUM_LEVELS];
  logic [NUM_LEVELS-1:0] ok_q;

  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        ok_q[g]   <= 1'b0;
      end else if (wr_en && (wr_level == LVL_W'(g))) begin
        ok_q[g] <= !wr_clear;
        if (!wr_clear) base_q[g] <= wr_base;
      end
    end
  end

  logic hit;
  always_comb begin
    hit     = wr_en && (wr_level == rd_level);
    rd_base = hit ? wr_base   : base_q[rd_level];
    rd_ok   = hit ? !wr_clear : ok_q[rd_level];
  end
endmodule

// File: rtl/lexaddr_split.sv
module lexaddr_split
  import lexaddr_pkg::*;
(
  input  logic [LVL_W-1:0]    cur_level,
  input  logic [COUPLE_W-1:0] couple,
  output logic [LVL_W-1:0]    level,
  output logic [COUPLE_W-1:0] offset,
  output logic                level_bad
);
  logic [COUPLE_W-1:0] shifted;
  logic [COUPLE_W-1:0] mask;
  int unsigned         fld_w;

  always_comb begin
    fld_w = 1;
    for (int i = 0; i < int'(LVL_W); i++)
      if (cur_level[i]) fld_w = i + 1;
    shifted   = couple >> (COUPLE_W - fld_w);
    mask      = (COUPLE_W'(1) << (COUPLE_W - fld_w)) - COUPLE_W'(1);
    level     = shifted[LVL_W-1:0];
    offset    = couple & mask;
    level_bad = level > cur_level;
  end
endmodule

// File: rtl/lexaddr_stage.sv
module lexaddr_stage
  import lexaddr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  logic [BASE_W-1:0]   base,
  input  logic                base_ok,
  input  logic [COUPLE_W-1:0] offset,
  input  logic                level_bad,
  input  logic                resp_ready,
  output logic                resp_valid,
  output resp_t               resp,
  output logic                req_ready
);
  logic [BASE_W:0] sum;
  logic            fault;

  always_comb begin
    sum       = {1'b0, base} + (BASE_W+1)'(offset);
    fault     = level_bad || !base_ok;
    req_ready = !resp_valid || resp_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp       <= '0;
    end else if (accept) begin
      resp_valid <= 1'b1;
      resp.fault <= fault;
      resp.ovf   <= !fault && sum[BASE_W];
      resp.addr  <= fault ? '0 : sum[BASE_W-1:0];
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lexaddr_unit.sv
module lexaddr_unit
  import lexaddr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [COUPLE_W-1:0] req_couple,
  output logic                resp_valid,
  input  logic                resp_ready,
  output logic [BASE_W-1:0]   resp_addr,
  output logic                resp_fault,
  output logic                resp_ovf,
  input  logic                wr_en,
  input  logic                wr_clear,
  input  logic [LVL_W-1:0]    wr_level,
  input  logic [BASE_W-1:0]   wr_base,
  input  logic                lvl_we,
  input  logic [LVL_W-1:0]    lvl_value,
  output logic [LVL_W-1:0]    cur_level
);
  logic [LVL_W-1:0]    sel_level;
  logic [COUPLE_W-1:0] sel_offset;
  logic                sel_bad;
  logic [BASE_W-1:0]   sel_base;
  logic                sel_ok;
  logic                accept;
  resp_t               resp;

  always_ff @(posedge clk) begin
    if (!rst_n)      cur_level <= '0;
    else if (lvl_we) cur_level <= lvl_value;
  end

  lexaddr_split u_split (
    .cur_level (cur_level),
    .couple    (req_couple),
    .level     (sel_level),
    .offset    (sel_offset),
    .level_bad (sel_bad)
  );

  lexaddr_display u_display (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_clear (wr_clear),
    .wr_level (wr_level),
    .wr_base  (wr_base),
    .rd_level (sel_level),
    .rd_base  (sel_base),
    .rd_ok    (sel_ok)
  );

  assign accept = req_valid && req_ready;

  lexaddr_stage u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .base       (sel_base),
    .base_ok    (sel_ok),
    .offset     (sel_offset),
    .level_bad  (sel_bad),
    .resp_ready (resp_ready),
    .resp_valid (resp_valid),
    .resp       (resp),
    .req_ready  (req_ready)
  );

  assign resp_addr  = resp.addr;
  assign resp_fault = resp.fault;
  assign resp_ovf   = resp.ovf;
endmodule

// File: rtl/lexaddr_unit_chk.sv
module lexaddr_unit_chk
  import lexaddr_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [COUPLE_W-1:0] req_couple,
  input logic                resp_valid,
  input logic                resp_ready,
  input logic [BASE_W-1:0]   resp_addr,
  input logic                resp_fault,
  input logic                resp_ovf,
  input logic                lvl_we,
  input logic [LVL_W-1:0]    lvl_value,
  input logic [LVL_W-1:0]    cur_level
);
  function automatic logic [LVL_W-1:0] top_field(input logic [LVL_W-1:0] cur,
                                                 input logic [COUPLE_W-1:0] c);
    int unsigned w = 1;
    logic [COUPLE_W-1:0] s;
    for (int i = 0; i < int'(LVL_W); i++) if (cur[i]) w = i + 1;
    s = c >> (COUPLE_W - w);
    return s[LVL_W-1:0];
  endfunction

  // R4: a request naming a deeper level than the current one must fault
  p_level_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (top_field(cur_level, req_couple) > cur_level))
      |=> (resp_valid && resp_fault));

  // R4: a faulting response carries no address and no overflow
  p_fault_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_addr == '0 && !resp_ovf));

  // R7: an accepted request yields a response on the next edge
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);

  // R7: a stalled response stays frozen
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_addr)
                                     && $stable(resp_fault) && $stable(resp_ovf)));

  // R7: an empty output register never stalls the request side
  p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_valid |-> req_ready);

  // R9: the level load takes effect on the next edge
  p_level_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_we |=> (cur_level == $past(lvl_value)));
endmodule

bind lexaddr_unit lexaddr_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_couple (req_couple),
  .resp_valid (resp_valid),
  .resp_ready (resp_ready),
  .resp_addr  (resp_addr),
  .resp_fault (resp_fault),
  .resp_ovf   (resp_ovf),
  .lvl_we     (lvl_we),
  .lvl_value  (lvl_value),
  .cur_level  (cur_level)
);

// File: tb/lexaddr_unit_bench.sv
module lexaddr_unit_bench;
  import lexaddr_pkg::*;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [COUPLE_W-1:0] req_couple = '0;
  logic                resp_valid;
  logic                resp_ready = 1'b1;
  logic [BASE_W-1:0]   resp_addr;
  logic                resp_fault;
  logic                resp_ovf;
  logic                wr_en = 1'b0;
  logic                wr_clear = 1'b0;
  logic [LVL_W-1:0]    wr_level = '0;
  logic [BASE_W-1:0]   wr_base = '0;
  logic                lvl_we = 1'b0;
  logic [LVL_W-1:0]    lvl_value = '0;
  logic [LVL_W-1:0]    cur_level;

  always #5 clk = ~clk;

  lexaddr_unit u_lexaddr_unit (.*);

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  logic [BASE_W-1:0] m_base [NUM_LEVELS];
  logic              m_ok   [NUM_LEVELS];
  logic [LVL_W-1:0]  m_cur = '0;
  logic              e_valid = 1'b0;
  logic [BASE_W-1:0] e_addr = '0;
  logic              e_fault = 1'b0;
  logic              e_ovf = 1'b0;

  task automatic check(input string t, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic void split(input logic [LVL_W-1:0] cur, input logic [COUPLE_W-1:0] c,
                                output int lev, output int off);
    int w = 1;
    for (int i = 0; i < int'(LVL_W); i++) if (cur[i]) w = i + 1;
    lev = int'(c) >> (COUPLE_W - w);
    off = int'(c) & ((1 << (COUPLE_W - w)) - 1);
  endfunction

  task automatic step(input logic rv, input logic [COUPLE_W-1:0] cp, input logic rr,
                      input logic we, input logic wc, input logic [LVL_W-1:0] wl,
                      input logic [BASE_W-1:0] wb, input logic lwe, input logic [LVL_W-1:0] lv);
    logic acc;
    int lev, off;
    logic [BASE_W-1:0] b;
    logic ok, flt;
    logic [BASE_W:0] sum;
    req_valid = rv; req_couple = cp; resp_ready = rr;
    wr_en = we; wr_clear = wc; wr_level = wl; wr_base = wb;
    lvl_we = lwe; lvl_value = lv;
    #1;
    check({tag, " R7 req_ready"}, req_ready, (!e_valid || rr));
    acc = rv && (!e_valid || rr);
    if (acc) begin
      split(m_cur, cp, lev, off);
      if (we && int'(wl) == lev) begin b = wb; ok = !wc; end
      else begin b = m_base[lev]; ok = m_ok[lev]; end
      flt = (lev > int'(m_cur)) || !ok;
      sum = {1'b0, b} + (BASE_W+1)'(off);
      e_valid = 1'b1; e_fault = flt;
      e_ovf  = !flt && sum[BASE_W];
      e_addr = flt ? '0 : sum[BASE_W-1:0];
    end else if (rr) e_valid = 1'b0;
    if (we) begin m_ok[wl] = !wc; if (!wc) m_base[wl] = wb; end
    if (lwe) m_cur = lv;
    @(posedge clk);
    @(negedge clk);
    check({tag, " R7 resp_valid"}, resp_valid, e_valid);
    if (e_valid) begin
      check({tag, " R3 addr"}, resp_addr, e_addr);
      check({tag, " R4 fault"}, resp_fault, e_fault);
      check({tag, " R3 ovf"}, resp_ovf, e_ovf);
    end
    check({tag, " R9 cur_level"}, cur_level, m_cur);
  endtask

  task automatic req(input logic [COUPLE_W-1:0] cp);
    step(1'b1, cp, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0);
  endtask
  task automatic wr(input logic [LVL_W-1:0] l, input logic [BASE_W-1:0] b, input logic clr);
    step(1'b0, '0, 1'b1, 1'b1, clr, l, b, 1'b0, '0);
  endtask
  task automatic setlvl(input logic [LVL_W-1:0] l);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1, l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < int'(NUM_LEVELS); i++) begin m_base[i] = '0; m_ok[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 resp_valid", resp_valid, 0);
    check("R1 cur_level", cur_level, 0);
    check("R1 req_ready", req_ready, 1);
    @(negedge clk);

    tag = "R5"; req(14'h0003);               // level 0 never written: fault
    tag = "R8"; wr(0, 20'd100, 1'b0); req(14'h0005);   // 105
    wr(0, 20'd0, 1'b1); req(14'h0005);                 // cleared: fault
    wr(0, 20'd200, 1'b0);
    tag = "R4"; req(14'h2003);               // cur 0: level 1 > 0
    tag = "R2"; req(14'h1FFF);               // cur 0, 1-bit field: level 0, offset 0x1FFF
    setlvl(5); wr(5, 20'h01000, 1'b0); wr(4, 20'h02000, 1'b0);
    req({3'b101, 11'd7});                    // level 5 offset 7
    req({3'b100, 11'h7FF});                  // level 4 offset 0x7FF
    tag = "R4"; req({3'b110, 11'd1});        // level 6 > 5
    tag = "R9"; step(1'b1, {3'b110, 11'd1}, 1'b1, 1'b0, 1'b0, '0, '0, 1'b1, 31); // old level decodes
    tag = "R2"; wr(31, 20'h00040, 1'b0); req({5'd31, 9'h1FF});
    tag = "R3"; wr(1, 20'hFFFF0, 1'b0); req({5'd1, 9'h020});   // wraps, overflow
    tag = "R6"; step(1'b1, {5'd2, 9'd3}, 1'b1, 1'b1, 1'b0, 2, 20'h00500, 1'b0, '0);
    step(1'b1, {5'd2, 9'd3}, 1'b1, 1'b1, 1'b1, 2, 20'h0, 1'b0, '0);
    tag = "R7";
    step(1'b1, {5'd5, 9'd1}, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0);
    step(1'b1, {5'd4, 9'd2}, 1'b0, 1'b0, 1'b0, '0, '0, 1'b0, '0);
    step(1'b1, {5'd4, 9'd2}, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0);
    step(1'b0, '0, 1'b1, 1'b0, 1'b0, '0, '0, 1'b0, '0);

    tag = "R3";
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], 14'($urandom), r[3:2] != 2'b00,
           r[4] & r[5], r[6] & r[7] & r[8], LVL_W'($urandom),
           BASE_W'($urandom), (r[9] & r[10] & r[11]), LVL_W'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule